// File: doc/BRIEF.md
# GPIO Controller with Edge-Event Interrupts

This block is a 32-pin general-purpose I/O peripheral. It sits on a simple register bus. A write takes one clock cycle, and a read returns data combinationally from the addressed register. Each pin is configured through three per-pin bits: direction, open-drain enable and output data. The pads are modelled as three separate vectors: out, output-enable and in. Each vector is indexed by pin number.

Pad inputs pass through a two-flop synchronizer and are then edge-detected. Each pin has a sense bit that selects falling-edge-only or both-edge detection. A detected edge sets a sticky event bit, which software clears by writing a one to it. The per-pin mask bits gate the events onto one interrupt request line.

In every register, pin n is held in bit 31-n, so pin 0 is the most significant bit. Software writes an output value to a shadow data register. For output pins, reading the data register returns that shadow value. For input pins, it returns the synchronized pad level.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, every pin is an input, pad_oe is all zero and irq is low. The direction, open-drain, event, mask and sense registers all read zero.
- R2: The register byte offsets are: direction 0x00, open-drain 0x04, data 0x08, event 0x0C, mask 0x10, sense 0x14. Direction, open-drain, mask and sense read back exactly what was written.
- R3: Pin n corresponds to register bit 31-n in every register, and to bit n of pad_in, pad_out and pad_oe.
- R4: A direction bit of 1 makes its pin an output and a direction bit of 0 makes it an input. An output pin in push-pull mode (open-drain bit 0) has pad_oe=1 and drives pad_out equal to its data bit. An input pin never has pad_oe set.
- R5: An output pin in open-drain mode (open-drain bit 1) behaves as follows. A data bit of 0 gives pad_oe=1 with pad_out=0. A data bit of 1 releases the pad (pad_oe=0). pad_out is never 1 while the pad is driven in this mode.
- R6: Reading the data register returns, for each bit, the last written data value if the pin is an output. If the pin is an input, it returns the pad level after a two-flop synchronizer.
- R7: With a sense bit of 0, both a rising and a falling synchronized edge on that pin set its event bit.
- R8: With a sense bit of 1, only a falling edge sets the event bit; a rising edge leaves it unchanged.
- R9: Writing the event register clears every bit written as 1 and leaves every bit written as 0 unchanged. An event bit stays set until it is cleared this way.
- R10: If a new edge and a clearing write hit the same event bit in the same cycle, the bit stays set.
- R11: irq is high exactly while the bitwise AND of the event and mask registers is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pad_in | input | 32 | Pad input levels, bit n = pin n |
| pad_out | output | 32 | Pad output values, bit n = pin n |
| pad_oe | output | 32 | Pad output enables, bit n = pin n |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that pad_in holds known 0/1 values and that bus_we is never X once reset is released. They also assume pad_in is low while reset is active, because the synchronizer resets to zero and a high pad at release would show up as a rising edge. The stimulus keeps to these assumptions. It changes pad_in only at falling clock edges and only while reset is released, one pin at a time during the edge sweeps. It then waits long enough for the synchronizer and edge stages to settle before it reads the event register. The collision test deliberately places a clearing write in the exact cycle where the edge is latched, so that the priority rule is exercised.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int GPIO_PINS = 32;
  localparam int REG_AW    = 8;

  typedef logic [GPIO_PINS-1:0] word_t;

  localparam logic [REG_AW-1:0] OFS_DIR   = 8'h00;
  localparam logic [REG_AW-1:0] OFS_ODRN  = 8'h04;
  localparam logic [REG_AW-1:0] OFS_DATA  = 8'h08;
  localparam logic [REG_AW-1:0] OFS_EVENT = 8'h0C;
  localparam logic [REG_AW-1:0] OFS_MASK  = 8'h10;
  localparam logic [REG_AW-1:0] OFS_SENSE = 8'h14;

  // Register bit holding pin n.
  function automatic int pin_bit(input int n);
    return GPIO_PINS - 1 - n;
  endfunction

  // Converts between register order and pin order (self-inverse).
  function automatic word_t flip(input word_t v);
    word_t r;
    for (int i = 0; i < GPIO_PINS; i++) r[i] = v[GPIO_PINS-1-i];
    return r;
  endfunction

  // Read value of the data register: shadow for outputs, level for inputs.
  function automatic word_t data_view(input word_t dir, input word_t shadow,
                                      input word_t level);
    return (shadow & dir) | (level & ~dir);
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] level,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign level = sync_q;
  assign rise  = sync_q & ~prev_q;
  assign fall  = ~sync_q & prev_q;
endmodule

// File: rtl/gpio_event_bank.sv
module gpio_event_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rise,
  input  logic [W-1:0] fall,
  input  logic [W-1:0] sense,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] evt,
  output logic [W-1:0] hit
);
  logic [W-1:0] evt_q;

  for (genvar b = 0; b < W; b++) begin : g_sense
    assign hit[b] = sense[b] ? fall[b] : (rise[b] | fall[b]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= (evt_q & ~clr_bits) | hit;
  end

  assign evt = evt_q;

  assert_evt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(evt_q) & ~$past(clr_bits)) & ~evt_q) == '0));

  assert_evt_from_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt_q & ~$past(evt_q) & ~$past(rise | fall)) == '0));

  assert_rise_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit & sense & rise) == '0);

  assert_edge_beats_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit & clr_bits) != '0) |=> ((evt_q & $past(hit & clr_bits)) == $past(hit & clr_bits)));
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
  parameter int W = 32
) (
  input  logic [W-1:0] dir,
  input  logic [W-1:0] odrn,
  input  logic [W-1:0] shadow,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);
  for (genvar n = 0; n < W; n++) begin : g_pin
    localparam int B = W - 1 - n;
    assign pad_oe[n]  = dir[B] & (~odrn[B] | ~shadow[B]);
    assign pad_out[n] = shadow[B] & ~odrn[B];
  end
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [GPIO_PINS-1:0] bus_wdata,
  output logic [GPIO_PINS-1:0] bus_rdata,
  input  logic [GPIO_PINS-1:0] pad_in,
  output logic [GPIO_PINS-1:0] pad_out,
  output logic [GPIO_PINS-1:0] pad_oe,
  output logic              irq
);
  word_t dir_q, odrn_q, shadow_q, mask_q, sense_q;
  word_t level, rise, fall, evt, hit, clr_bits;

  logic wr_dir, wr_odrn, wr_data, wr_evt, wr_mask, wr_sense;
  assign wr_dir   = bus_we && (bus_addr == OFS_DIR);
  assign wr_odrn  = bus_we && (bus_addr == OFS_ODRN);
  assign wr_data  = bus_we && (bus_addr == OFS_DATA);
  assign wr_evt   = bus_we && (bus_addr == OFS_EVENT);
  assign wr_mask  = bus_we && (bus_addr == OFS_MASK);
  assign wr_sense = bus_we && (bus_addr == OFS_SENSE);
  assign clr_bits = wr_evt ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q    <= '0;
      odrn_q   <= '0;
      shadow_q <= '0;
      mask_q   <= '0;
      sense_q  <= '0;
    end else begin
      if (wr_dir)   dir_q    <= bus_wdata;
      if (wr_odrn)  odrn_q   <= bus_wdata;
      if (wr_data)  shadow_q <= bus_wdata;
      if (wr_mask)  mask_q   <= bus_wdata;
      if (wr_sense) sense_q  <= bus_wdata;
    end
  end

  gpio_in_sync #(.W(GPIO_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(flip(pad_in)),
    .level(level), .rise(rise), .fall(fall)
  );

  gpio_event_bank #(.W(GPIO_PINS)) u_events (
    .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall), .sense(sense_q),
    .clr_bits(clr_bits), .evt(evt), .hit(hit)
  );

  gpio_pad_drive #(.W(GPIO_PINS)) u_pads (
    .dir(dir_q), .odrn(odrn_q), .shadow(shadow_q),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  always_comb begin
    case (bus_addr)
      OFS_DIR:   bus_rdata = dir_q;
      OFS_ODRN:  bus_rdata = odrn_q;
      OFS_DATA:  bus_rdata = data_view(dir_q, shadow_q, level);
      OFS_EVENT: bus_rdata = evt;
      OFS_MASK:  bus_rdata = mask_q;
      OFS_SENSE: bus_rdata = sense_q;
      default:   bus_rdata = '0;
    endcase
  end

  assign irq = |(evt & mask_q);

  assert_input_undriven_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~flip(dir_q)) == '0);

  assert_odrain_no_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_out & flip(odrn_q)) == '0);

  assert_irq_needs_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((evt != '0) && (mask_q != '0)));
endmodule

// File: tb/gpio_edge_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_edge_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  localparam logic [7:0] A_DIR = 8'h00, A_OD = 8'h04, A_DAT = 8'h08,
                         A_EVT = 8'h0C, A_MSK = 8'h10, A_SNS = 8'h14;

  always #4 clk = ~clk;

  gpio_edge_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  function automatic logic [31:0] rev(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[31-i] = v[i];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_DIR, v); chk("R1 dir", v, 32'h0);
    rd(A_OD, v);  chk("R1 od", v, 32'h0);
    rd(A_EVT, v); chk("R1 evt", v, 32'h0);
    rd(A_MSK, v); chk("R1 msk", v, 32'h0);
    rd(A_SNS, v); chk("R1 sense", v, 32'h0);
    chk("R1 pad_oe", pad_oe, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R2 readback at each offset
    for (int p = 0; p < 3; p++) begin
      logic [31:0] pat;
      pat = (p == 0) ? 32'hDEADBEEF : (p == 1) ? 32'h0123_4567 : 32'hFFFF_0000;
      wr(A_MSK, pat);  rd(A_MSK, v); chk("R2 msk", v, pat);
      wr(A_SNS, ~pat); rd(A_SNS, v); chk("R2 sense", v, ~pat);
      wr(A_OD, pat ^ 32'h5A5A5A5A); rd(A_OD, v); chk("R2 od", v, pat ^ 32'h5A5A5A5A);
      wr(A_DIR, pat); rd(A_DIR, v); chk("R2 dir", v, pat);
    end
    wr(A_MSK, 0); wr(A_SNS, 0); wr(A_OD, 0);

    // R3/R4 pin mapping sweep, push-pull
    wr(A_DAT, 32'hFFFFFFFF);
    for (int n = 0; n < 32; n++) begin
      wr(A_DIR, 32'h1 << (31 - n));
      chk("R3 R4 oe map", pad_oe, 32'h1 << n);
      chk("R3 R4 out", pad_out, 32'hFFFFFFFF);
    end
    wr(A_DIR, 32'hFFFFFFFF);
    wr(A_DAT, 32'hC3A50F96);
    chk("R4 push-pull out", pad_out, rev(32'hC3A50F96));
    chk("R4 push-pull oe", pad_oe, 32'hFFFFFFFF);

    // R5 open-drain
    wr(A_OD, 32'hFFFFFFFF);
    chk("R5 od oe", pad_oe, rev(~32'hC3A50F96));
    chk("R5 od out", pad_out, 32'h0);
    wr(A_DIR, 32'h0);
    chk("R4 input undriven", pad_oe, 32'h0);
    wr(A_OD, 32'h0);

    // R6 data read mix
    wr(A_DIR, 32'hFFFF0000);
    wr(A_DAT, 32'hA5A55A5A);
    pad_in = 32'h3C3C_F00F;
    settle();
    rd(A_DAT, v);
    chk("R6 data view", v, (32'hA5A55A5A & 32'hFFFF0000) | (rev(32'h3C3CF00F) & 32'h0000FFFF));
    pad_in = ~pad_in;
    settle();
    rd(A_DAT, v);
    chk("R6 data view inv", v, (32'hA5A55A5A & 32'hFFFF0000) | (rev(~32'h3C3CF00F) & 32'h0000FFFF));
    @(negedge clk); pad_in = '0;
    wr(A_DIR, 0);
    settle();
    wr(A_EVT, 32'hFFFFFFFF);

    // R7/R8 per-pin edge sweep for both sense settings
    for (int s = 0; s < 2; s++) begin
      wr(A_SNS, s ? 32'hFFFFFFFF : 32'h0);
      for (int n = 0; n < 32; n++) begin
        @(negedge clk); pad_in[n] = 1'b1;
        settle();
        rd(A_EVT, v);
        chk(s ? "R8 rise ignored" : "R7 rise event", v, s ? 32'h0 : (32'h1 << (31 - n)));
        wr(A_EVT, 32'hFFFFFFFF);
        @(negedge clk); pad_in[n] = 1'b0;
        settle();
        rd(A_EVT, v);
        chk(s ? "R8 fall event" : "R7 fall event", v, 32'h1 << (31 - n));
        wr(A_EVT, 32'hFFFFFFFF);
      end
    end
    wr(A_SNS, 0);

    // R9 partial clear
    @(negedge clk); pad_in = 32'hFFFFFFFF;
    settle();
    rd(A_EVT, v); chk("R9 all set", v, 32'hFFFFFFFF);
    wr(A_EVT, 32'h0F0F0F0F);
    rd(A_EVT, v); chk("R9 partial clear", v, 32'hF0F0F0F0);
    wr(A_EVT, 32'h0);
    rd(A_EVT, v); chk("R9 zero write", v, 32'hF0F0F0F0);

    // R11 irq gating
    wr(A_MSK, 32'h0);
    chk("R11 masked", {31'b0, irq}, 32'h0);
    wr(A_MSK, 32'h0F000000);
    chk("R11 no overlap", {31'b0, irq}, 32'h0);
    wr(A_MSK, 32'h00100000);
    chk("R11 overlap", {31'b0, irq}, 32'h1);
    wr(A_EVT, 32'h00100000);
    chk("R11 cleared", {31'b0, irq}, 32'h0);
    wr(A_MSK, 0);
    wr(A_EVT, 32'hFFFFFFFF);

    // R10 collision: pin 5 falls while its bit is being cleared
    rd(A_EVT, v); chk("R10 pre clear", v, 32'h0);
    @(negedge clk); pad_in = 32'hFFFFFFDF;
    settle();
    wr(A_EVT, 32'hFFFFFFFF);
    @(negedge clk); pad_in[5] = 1'b1;
    settle();
    rd(A_EVT, v); chk("R10 setup", v, 32'h1 << 26);
    @(negedge clk); pad_in[5] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    bus_addr = A_EVT; bus_wdata = 32'h1 << 26; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
    rd(A_EVT, v); chk("R10 edge wins", v, 32'h1 << 26);
    settle();
    wr(A_EVT, 32'h1 << 26);
    rd(A_EVT, v); chk("R10 later clear", v, 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule